// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character per request into an asynchronous serial frame on a single output line. The line rests high. A frame is a low start bit, then 5 to 8 data bits sent least significant bit first. An optional extra bit supplied with the character may follow the data, and an optional parity bit may follow that. The frame closes with a high stop period of one, one and a half or two bit times.

Bit timing comes from an external enable that pulses at sixteen times the baud rate. Each bit lasts sixteen of these pulses, and cycles without a pulse do not advance the frame. An 8-bit mode register with its own write port sets the frame format. The transmitter copies the mode when a frame starts, so a write during a frame applies to the next frame. Completion is reported by a busy flag and a single-cycle done pulse.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset `tx_line` is 1, `busy` is 0 and `done` is 0, and `tx_line` is 1 in every cycle in which `busy` is 0.
- R2: A `tx_start` pulse seen while `busy` is 0 sets `busy` and drives `tx_line` low from the next cycle. The start bit lasts 16 `baud_tick16` pulses, and cycles without a pulse do not advance the frame.
- R3: Mode bits [3:2] choose the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits follow the start bit least significant bit first, each lasting 16 ticks.
- R4: When mode bit [4] is 1, a parity bit is sent. Mode bits [6:5] choose its value: 0 makes the count of ones over the active data bits plus parity odd, 1 makes it even, 2 sends 1, and 3 sends 0. Data bits above the data length do not affect parity.
- R5: When mode bit [1] is 1, the `tx_extra` value is sent right after the data bits. When parity is also enabled, the parity bit comes after the extra bit.
- R6: With mode bit [0] at 0 the stop level lasts 16 ticks. With it at 1 the stop level lasts 32 ticks, or 24 ticks when the data length is 5.
- R7: The mode register resets to 8'h0C, which gives 8 data bits, no parity, no extra bit and a short stop. A write with `mode_we` high loads `mode_wdata` in full at the clock edge.
- R8: A `tx_start` pulse while `busy` is 1 is ignored: the frame in flight keeps its data and extra bit, and it produces only one `done`.
- R9: A mode write during a frame does not change that frame. The next frame uses the new mode.
- R10: `done` is high for exactly one cycle, the cycle after the clock edge that holds the last stop tick. `busy` falls in that same cycle.
- R11: Mode bit [7] (the multiprocessor flag) has no effect on the transmitted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| baud_tick16 | input | 1 | Oversample enable, 16 per bit |
| tx_start | input | 1 | Request to send one character |
| tx_data | input | 8 | Character to send |
| tx_extra | input | 1 | Value of the optional extra bit |
| tx_line | output | 1 | Serial output, high when idle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
Two situations are hardest to reach from the ports. One is a start request that arrives while a frame is in flight. The other is a mode write that lands in the middle of a frame, since either could quietly corrupt the frame in flight. Directed frames inject both about twenty cycles into a frame: the extra request carries inverted data and the mode write carries a different format. The bench then compares the whole frame, one sample per tick, against the old format. The tick enable arrives with random density, so segment boundaries fall on uneven cycle spacing, and random modes cover every mix of length, parity, extra bit and stop length.

// File: rtl/uart_frame_pkg.sv
`timescale 1ns/1ps
package uart_frame_pkg;

  // Mode register layout, MSB first.
  typedef struct packed {
    logic       mp_en;
    logic [1:0] par_kind;
    logic       par_en;
    logic [1:0] dlen;
    logic       xb_en;
    logic       stop_long;
  } tx_mode_t;

  localparam logic [7:0] MODE_RESET = 8'h0C;
  localparam int unsigned BODY_MAX = 10;   // 8 data + extra + parity
  localparam int unsigned BODY_LW  = $clog2(BODY_MAX + 1);

  function automatic int unsigned data_count(logic [1:0] dl);
    return 5 + int'(dl);
  endfunction

  function automatic logic parity_value(tx_mode_t m, logic [7:0] d);
    logic x;
    x = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(data_count(m.dlen))) x ^= d[i];
    case (m.par_kind)
      2'd0:    return ~x;
      2'd1:    return x;
      2'd2:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [BODY_MAX-1:0] body_bits(tx_mode_t m, logic [7:0] d, logic xb);
    logic [BODY_MAX-1:0] b;
    int unsigned pos;
    b   = '0;
    pos = data_count(m.dlen);
    for (int i = 0; i < 8; i++)
      if (i < int'(pos)) b[i] = d[i];
    if (m.xb_en) begin
      b[pos] = xb;
      pos++;
    end
    if (m.par_en) b[pos] = parity_value(m, d);
    return b;
  endfunction

  function automatic logic [BODY_LW-1:0] body_count(tx_mode_t m);
    return BODY_LW'(data_count(m.dlen) + int'(m.xb_en) + int'(m.par_en));
  endfunction

  function automatic int unsigned stop_ticks(tx_mode_t m, int unsigned ovs);
    if (!m.stop_long)    return ovs;
    if (m.dlen == 2'd0)  return ovs + ovs / 2;
    return 2 * ovs;
  endfunction

endpackage

// File: rtl/uart_tx_mode_reg.sv
`timescale 1ns/1ps
module uart_tx_mode_reg
  import uart_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  output tx_mode_t   mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= tx_mode_t'(MODE_RESET);
    else if (mode_we) mode_q <= tx_mode_t'(mode_wdata);
  end

  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> (mode_q == tx_mode_t'($past(mode_wdata))));

endmodule

// File: rtl/uart_tx_bit_timer.sv
`timescale 1ns/1ps
module uart_tx_bit_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          seg_end
);

  logic [CW-1:0] cnt;

  assign seg_end = run && tick && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || seg_end)  cnt <= '0;
    else if (tick)             cnt <= cnt + 1'b1;
  end

  // R2
  cnt_in_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));

  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt == $past(cnt) || cnt == '0));

endmodule

// File: rtl/uart_tx_frame_seq.sv
`timescale 1ns/1ps
module uart_tx_frame_seq
  import uart_frame_pkg::*;
#(
  parameter int unsigned OVS = 16,
  parameter int unsigned CW  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_start,
  input  logic [7:0]    tx_data,
  input  logic          tx_extra,
  input  tx_mode_t      mode,
  input  logic          seg_end,
  output logic          run,
  output logic [CW-1:0] seg_limit,
  output logic          tx_line,
  output logic          busy,
  output logic          done
);

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BODY, ST_STOP} seq_state_t;

  seq_state_t          state;
  logic [BODY_MAX-1:0] shreg;
  logic [BODY_LW-1:0]  left;
  logic [CW-1:0]       stop_lim;

  // named events for the checks
  logic start_acc;
  logic frame_end;

  assign start_acc = tx_start && (state == ST_IDLE);
  assign frame_end = seg_end && (state == ST_STOP);
  assign busy      = (state != ST_IDLE);
  assign run       = busy;
  assign seg_limit = (state == ST_STOP) ? stop_lim : CW'(OVS - 1);

  always_comb begin
    case (state)
      ST_START: tx_line = 1'b0;
      ST_BODY:  tx_line = shreg[0];
      default:  tx_line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      left     <= '0;
      stop_lim <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start_acc) begin
          shreg    <= body_bits(mode, tx_data, tx_extra);
          left     <= body_count(mode);
          stop_lim <= CW'(stop_ticks(mode, OVS) - 1);
          state    <= ST_START;
        end
        ST_START: if (seg_end) state <= ST_BODY;
        ST_BODY: if (seg_end) begin
          shreg <= shreg >> 1;
          left  <= left - 1'b1;
          if (left == BODY_LW'(1)) state <= ST_STOP;
        end
        default: if (frame_end) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (busy && !tx_line));

  // R10
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_end) |=> busy);

endmodule

// File: rtl/uart_frame_tx.sv
`timescale 1ns/1ps
module uart_frame_tx
  import uart_frame_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic [7:0] mode_wdata,
  input  logic       baud_tick16,
  input  logic       tx_start,
  input  logic [7:0] tx_data,
  input  logic       tx_extra,
  output logic       tx_line,
  output logic       busy,
  output logic       done
);

  localparam int unsigned CW = $clog2(2 * OVS);

  tx_mode_t      mode_q;
  logic          run;
  logic          seg_end;
  logic [CW-1:0] seg_limit;

  uart_tx_mode_reg u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .mode_q     (mode_q)
  );

  uart_tx_bit_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (baud_tick16),
    .limit   (seg_limit),
    .seg_end (seg_end)
  );

  uart_tx_frame_seq #(.OVS(OVS), .CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_start  (tx_start),
    .tx_data   (tx_data),
    .tx_extra  (tx_extra),
    .mode      (mode_q),
    .seg_end   (seg_end),
    .run       (run),
    .seg_limit (seg_limit),
    .tx_line   (tx_line),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: tb/uart_frame_tx_tb.sv
`timescale 1ns/1ps
module uart_frame_tx_tb;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       mode_we = 0;
  logic [7:0] mode_wdata = 0;
  logic       baud_tick16 = 0;
  logic       tx_start = 0;
  logic [7:0] tx_data = 0;
  logic       tx_extra = 0;
  logic       tx_line, busy, done;

  int nvec = 0;
  int nerr = 0;
  int tick_den = 1;
  int done_cnt = 0;
  logic [7:0] cur_mode = 8'h0C;
  bit samp[$];
  bit expq[$];

  uart_frame_tx u_dut (.*);

  always #4 clk = ~clk;   // 125 MHz

  initial begin
    #(8ns * 190000);
    nerr++;
    $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  // tick driver
  initial begin
    forever begin
      @(posedge clk); #1;
      baud_tick16 = (($urandom % tick_den) == 0);
    end
  end

  // monitor
  always @(negedge clk) begin
    if (busy && baud_tick16) samp.push_back(tx_line);
    if (done) done_cnt++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit exp_parity(logic [7:0] m, logic [7:0] d);
    int n = 5 + int'(m[3:2]);
    int ones = $countones(d & 8'((1 << n) - 1));
    case (m[6:5])
      2'd0: return (ones % 2) == 0;
      2'd1: return (ones % 2) == 1;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void build_exp(logic [7:0] m, logic [7:0] d, logic x);
    int n = 5 + int'(m[3:2]);
    int st;
    expq.delete();
    repeat (16) expq.push_back(1'b0);
    for (int i = 0; i < n; i++) repeat (16) expq.push_back(d[i]);
    if (m[1]) repeat (16) expq.push_back(x);
    if (m[4]) repeat (16) expq.push_back(exp_parity(m, d));
    st = !m[0] ? 16 : (n == 5 ? 24 : 32);
    repeat (st) expq.push_back(1'b1);
  endfunction

  task automatic write_mode(logic [7:0] v);
    @(posedge clk); #1;
    mode_we = 1; mode_wdata = v;
    @(posedge clk); #1;
    mode_we = 0;
  endtask

  task automatic run_frame(string req, logic [7:0] d, logic x, bit disturb, logic [7:0] nmode);
    int bad;
    build_exp(cur_mode, d, x);
    @(posedge clk); #1;
    samp.delete(); done_cnt = 0;
    tx_start = 1; tx_data = d; tx_extra = x;
    @(posedge clk); #1;
    tx_start = 0;
    @(negedge clk);
    chk(busy && !tx_line, "R2 start", {busy, tx_line}, 2);
    if (disturb) begin
      repeat (20) @(posedge clk);
      #1; tx_start = 1; tx_data = ~d; tx_extra = ~x;
      @(posedge clk); #1; tx_start = 0;
      write_mode(nmode);
    end
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    chk(!done && !busy && done_cnt == 1, "R10/R8 done pulse", {done, busy, 8'(done_cnt)}, 1);
    chk(tx_line, "R1 idle line", tx_line, 1);
    bad = -1;
    if (samp.size() != expq.size()) bad = 9999;
    else foreach (samp[i]) if (bad < 0 && samp[i] != expq[i]) bad = i;
    chk(bad < 0, req, samp.size(), expq.size());
    if (bad >= 0 && bad != 9999)
      $display("  first mismatch at tick %0d: actual %0d expected %0d", bad, samp[bad], expq[bad]);
    if (disturb) cur_mode = nmode;
  endtask

  task automatic set_mode(logic [7:0] v);
    write_mode(v);
    cur_mode = v;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(tx_line && !busy && !done, "R1 reset", {tx_line, busy, done}, 4);
    // R7 reset mode: 8 bits, no parity, short stop
    run_frame("R7 reset mode frame", 8'hA5, 1'b1, 0, 8'h00);
    // R3 each data length
    for (int l = 0; l < 4; l++) begin
      set_mode(8'(l << 2));
      run_frame("R3 data length", 8'hD3, 1'b0, 0, 8'h00);
    end
    // R4 parity kinds with high unused bits set
    tick_den = 2;
    for (int p = 0; p < 4; p++) begin
      set_mode(8'((p << 5) | 8'h10 | 8'h04));
      run_frame("R4 parity", 8'hE5, 1'b0, 0, 8'h00);
    end
    // R5 extra then parity
    set_mode(8'b0_00_1_11_1_0);
    run_frame("R5 extra+parity order", 8'h3C, 1'b1, 0, 8'h00);
    // R6 long stop, 5 bits and 8 bits
    set_mode(8'b0_01_0_00_0_1);
    run_frame("R6 stop 1.5", 8'h15, 1'b0, 0, 8'h00);
    set_mode(8'b0_01_0_11_0_1);
    run_frame("R6 stop 2", 8'h81, 1'b0, 0, 8'h00);
    // R11 multiprocessor bit without effect
    set_mode(8'b1_01_1_10_1_0);
    run_frame("R11 mp bit", 8'h6B, 1'b0, 0, 8'h00);
    // R8 / R9 start and mode write during a frame
    tick_den = 3;
    set_mode(8'b0_00_1_11_0_0);
    run_frame("R8/R9 disturbed frame", 8'h4E, 1'b1, 1, 8'b0_11_1_01_1_1);
    run_frame("R9 new mode next frame", 8'h27, 1'b1, 0, 8'h00);
    // random frames
    for (int k = 0; k < 40; k++) begin
      tick_den = 1 + ($urandom % 4);
      set_mode(8'($urandom));
      run_frame("R3/R4/R5/R6 random", 8'($urandom), 1'($urandom), (k % 8) == 7, 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule